// File: doc/BRIEF.md
# ISA Memory Cycle Command Sequencer

This block times the memory command strobes for a bridge that masters a 16-bit ISA-style bus. A request carries a 27-bit address, a read/write flag and a cycle kind: bridge-initiated, DMA or refresh. Once a request is accepted, the block asserts the general memory read or write strobe. It stretches or shortens the command from the slave's ready and zero-wait inputs. When the command ends it raises a one-clock done pulse, and at the same time it reports whether the slave claimed a 16-bit memory transfer.

Two low-memory standard strobes sit next to the general strobes. They are asserted only for addresses under 1 MB. Each one starts one clock after its general strobe and releases in the same clock as that strobe. When another master owns the bus, the block drops the output enable of the general strobes so those pins act as inputs. It then derives the standard strobes from the incoming general strobes. It also drives the 16-bit memory select low when such a foreign cycle targets main memory. Pad tri-stating, arbitration, I/O cycles and data steering are handled elsewhere; the block only provides the enables.

Top module: `isa_mem_cmd_seq`

## Requirements
- R1: While rst_ni is low, memrw_oe_o is 0, smemr_n_o and smemw_n_o are 1 (driven, not floated), done_o is 0 and mem16_oe_o is 0 while ext_master_i is 0.
- R2: memrw_oe_o rises one clock after reset release while ext_master_i is 0. With ext_master_i held high for two clocks while idle, memrw_oe_o is 0 and req_ready_o is 0, so no request is accepted.
- R3: An accepted request with req_kind_i = 0 (bridge) or 1 (DMA) drives memr_n_o low for req_write_i = 0 and memw_n_o low for req_write_i = 1. req_kind_i = 2 (refresh) always drives memr_n_o low, whatever req_write_i is. The two strobes are never low together.
- R4: A standard strobe asserts only when the cycle address is below 0x0010_0000. At 0x0010_0000 and above it stays high for the whole cycle.
- R5: A standard strobe goes low one clock after the matching general strobe goes low, and it goes high in the same clock as that strobe.
- R6: With ready_i high and zero_ws_n_i high, the general strobe stays low for exactly 3 clocks.
- R7: zero_ws_n_i low together with ready_i high, sampled in a command clock, ends the command after that clock. This makes a 1-clock command possible.
- R8: Each command clock with ready_i low adds one clock to the command. A zero_ws_n_i low in such a clock is ignored.
- R9: done_o is high for exactly the one clock in which the general strobe has just returned high. In that clock bus16_o equals the inverse of mem16_n_i sampled in the last command clock.
- R10: With memrw_oe_o low, smemr_n_o and smemw_n_o follow ext_memr_n_i and ext_memw_n_i with the same one-clock assertion delay. This happens only when ext_addr_i is below 0x0010_0000.
- R11: With ext_master_i high, ext_main_mem_i high and an external command strobe low, mem16_oe_o is 1 and mem16_n_o is 0. Otherwise mem16_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| req_valid_i | input | 1 | Cycle request |
| req_ready_o | output | 1 | Request accepted this clock when valid |
| req_addr_i | input | 27 | Cycle address |
| req_write_i | input | 1 | 1 = memory write |
| req_kind_i | input | 2 | 0 bridge, 1 DMA, 2 refresh |
| ext_master_i | input | 1 | Another master owns the bus |
| ext_addr_i | input | 27 | Address of the foreign master cycle |
| ext_memr_n_i | input | 1 | General read strobe from the foreign master |
| ext_memw_n_i | input | 1 | General write strobe from the foreign master |
| ext_main_mem_i | input | 1 | Foreign cycle targets main memory |
| mem16_n_i | input | 1 | Slave claims 16-bit memory transfer (low) |
| zero_ws_n_i | input | 1 | Slave zero-wait request (low) |
| ready_i | input | 1 | Slave ready; low inserts waits |
| memr_n_o | output | 1 | General memory read strobe |
| memw_n_o | output | 1 | General memory write strobe |
| memrw_oe_o | output | 1 | Pad enable for both general strobes |
| smemr_n_o | output | 1 | Low-memory read strobe |
| smemw_n_o | output | 1 | Low-memory write strobe |
| mem16_n_o | output | 1 | 16-bit select driven by the bridge |
| mem16_oe_o | output | 1 | Pad enable for the 16-bit select |
| done_o | output | 1 | Command finished pulse |
| bus16_o | output | 1 | Slave was 16-bit in the finished cycle |

## Verification
The assertions assume that ext_master_i changes only while no bridge command is running. They also assume that ready_i, zero_ws_n_i and mem16_n_i are known in every command clock and that the external strobes are never low together. The bench toggles bus ownership only between cycles. It drives the slave inputs in every command clock, using random ready and zero-wait values with a fixed seed mixed with directed patterns. It lowers only one external strobe at a time.

// File: rtl/isa_cmd_pkg.sv
package isa_cmd_pkg;
  typedef enum logic [1:0] {
    CYC_BRIDGE  = 2'd0,
    CYC_DMA     = 2'd1,
    CYC_REFRESH = 2'd2
  } cyc_kind_e;

  localparam int unsigned N_STROBE = 2;
  localparam int unsigned STB_RD   = 0;
  localparam int unsigned STB_WR   = 1;
endpackage

// File: rtl/isa_low_decode.sv
module isa_low_decode #(
  parameter int unsigned          ADDR_W = 27,
  parameter logic [ADDR_W-1:0]    LIMIT  = 27'h010_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              low_o
);
  assign low_o = (addr_i < LIMIT);
endmodule

// File: rtl/isa_cmd_timer.sv
module isa_cmd_timer #(
  parameter int unsigned DEF_CLKS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ready_i,
  input  logic zero_ws_n_i,
  output logic busy_o,
  output logic end_o
);
  localparam int unsigned CNT_W = $clog2(DEF_CLKS) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEF_CLKS - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  // not-ready has precedence over zero-wait
  assign end_o  = busy_q && ready_i && (!zero_ws_n_i || cnt_q == LAST);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (end_o) begin
      busy_q <= 1'b0;
    end else if (busy_q && ready_i) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/isa_std_strobe.sv
module isa_std_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic low_i,
  output logic std_n_o
);
  logic arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else         arm_q <= act_i && low_i;
  end

  // delayed on assertion, released with the general strobe
  assign std_n_o = !(arm_q && act_i && low_i);
endmodule

// File: rtl/isa_mem_cmd_seq.sv
module isa_mem_cmd_seq
  import isa_cmd_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 27,
  parameter logic [ADDR_W-1:0] LOW_LIMIT = 27'h010_0000,
  parameter int unsigned       DEF_CLKS  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [1:0]        req_kind_i,
  input  logic              ext_master_i,
  input  logic [ADDR_W-1:0] ext_addr_i,
  input  logic              ext_memr_n_i,
  input  logic              ext_memw_n_i,
  input  logic              ext_main_mem_i,
  input  logic              mem16_n_i,
  input  logic              zero_ws_n_i,
  input  logic              ready_i,
  output logic              memr_n_o,
  output logic              memw_n_o,
  output logic              memrw_oe_o,
  output logic              smemr_n_o,
  output logic              smemw_n_o,
  output logic              mem16_n_o,
  output logic              mem16_oe_o,
  output logic              done_o,
  output logic              bus16_o
);
  logic              own_q;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  cyc_kind_e         kind_q;
  logic              done_q;
  logic              bus16_q;

  logic busy, cyc_end, start;
  logic rd_act, wr_act;
  logic low_int, low_ext, low_sel;
  logic [N_STROBE-1:0] act_sel;
  logic [N_STROBE-1:0] std_n;

  assign req_ready_o = own_q && !busy && !ext_master_i;
  assign start       = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q   <= 1'b0;
      addr_q  <= '0;
      write_q <= 1'b0;
      kind_q  <= CYC_BRIDGE;
      done_q  <= 1'b0;
      bus16_q <= 1'b0;
    end else begin
      if (!busy) own_q <= !ext_master_i;
      if (start) begin
        addr_q  <= req_addr_i;
        write_q <= req_write_i;
        kind_q  <= (req_kind_i == 2'd2) ? CYC_REFRESH :
                   (req_kind_i == 2'd1) ? CYC_DMA : CYC_BRIDGE;
      end
      done_q <= cyc_end;
      if (cyc_end) bus16_q <= !mem16_n_i;
    end
  end

  isa_cmd_timer #(.DEF_CLKS(DEF_CLKS)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .ready_i     (ready_i),
    .zero_ws_n_i (zero_ws_n_i),
    .busy_o      (busy),
    .end_o       (cyc_end)
  );

  // refresh always uses the read command
  assign rd_act = busy && (kind_q == CYC_REFRESH || !write_q);
  assign wr_act = busy && kind_q != CYC_REFRESH && write_q;

  assign memr_n_o   = !rd_act;
  assign memw_n_o   = !wr_act;
  assign memrw_oe_o = own_q;

  isa_low_decode #(.ADDR_W(ADDR_W), .LIMIT(LOW_LIMIT)) u_dec_int (
    .addr_i (addr_q),
    .low_o  (low_int)
  );

  isa_low_decode #(.ADDR_W(ADDR_W), .LIMIT(LOW_LIMIT)) u_dec_ext (
    .addr_i (ext_addr_i),
    .low_o  (low_ext)
  );

  assign low_sel         = own_q ? low_int : low_ext;
  assign act_sel[STB_RD] = own_q ? rd_act : (ext_master_i && !ext_memr_n_i);
  assign act_sel[STB_WR] = own_q ? wr_act : (ext_master_i && !ext_memw_n_i);

  for (genvar g = 0; g < N_STROBE; g++) begin : g_std
    isa_std_strobe u_std (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (act_sel[g]),
      .low_i   (low_sel),
      .std_n_o (std_n[g])
    );
  end

  assign smemr_n_o = std_n[STB_RD];
  assign smemw_n_o = std_n[STB_WR];

  assign mem16_oe_o = ext_master_i && ext_main_mem_i && (!ext_memr_n_i || !ext_memw_n_i);
  assign mem16_n_o  = !mem16_oe_o;

  assign done_o  = done_q;
  assign bus16_o = bus16_q;
endmodule

// File: rtl/isa_mem_cmd_seq_chk.sv
module isa_mem_cmd_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ext_master_i,
  input logic ext_memr_n_i,
  input logic ext_memw_n_i,
  input logic ready_i,
  input logic memr_n_o,
  input logic memw_n_o,
  input logic memrw_oe_o,
  input logic smemr_n_o,
  input logic smemw_n_o,
  input logic done_o
);
  assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!memr_n_o && !memw_n_o));

  assert_ext_float_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_master_i && $past(ext_master_i) && memr_n_o && memw_n_o) |-> !memrw_oe_o);

  assert_std_follows_rd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (memrw_oe_o && $fell(smemr_n_o)) |-> (!memr_n_o && $past(!memr_n_o)));

  assert_std_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (memrw_oe_o && memr_n_o && memw_n_o) |-> (smemr_n_o && smemw_n_o));

  assert_wait_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (memrw_oe_o && !ready_i && (!memr_n_o || !memw_n_o)) |=>
      (!memr_n_o || !memw_n_o));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_at_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (memr_n_o && memw_n_o && $past(!memr_n_o || !memw_n_o)));

  assert_ext_std_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!memrw_oe_o && ext_memr_n_i && ext_memw_n_i) |-> (smemr_n_o && smemw_n_o));
endmodule

bind isa_mem_cmd_seq isa_mem_cmd_seq_chk u_chk (.*);

// File: tb/isa_mem_cmd_seq_tb.sv
module isa_mem_cmd_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [26:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic        ext_master = 1'b0;
  logic [26:0] ext_addr = '0;
  logic        ext_memr_n = 1'b1;
  logic        ext_memw_n = 1'b1;
  logic        ext_main = 1'b0;
  logic        mem16_n = 1'b1;
  logic        zws_n = 1'b1;
  logic        ready = 1'b1;
  logic memr_n, memw_n, memrw_oe, smemr_n, smemw_n, mem16_n_o, mem16_oe, done, bus16;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  isa_mem_cmd_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_write_i(req_write), .req_kind_i(req_kind),
    .ext_master_i(ext_master), .ext_addr_i(ext_addr), .ext_memr_n_i(ext_memr_n),
    .ext_memw_n_i(ext_memw_n), .ext_main_mem_i(ext_main), .mem16_n_i(mem16_n),
    .zero_ws_n_i(zws_n), .ready_i(ready), .memr_n_o(memr_n), .memw_n_o(memw_n),
    .memrw_oe_o(memrw_oe), .smemr_n_o(smemr_n), .smemw_n_o(smemw_n),
    .mem16_n_o(mem16_n_o), .mem16_oe_o(mem16_oe), .done_o(done), .bus16_o(bus16)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_low(input logic [26:0] a);
    return a < 27'h010_0000;
  endfunction

  function automatic bit uses_read(input bit wr, input logic [1:0] kind);
    return (kind == 2'd2) || !wr;
  endfunction

  // mode: 0 random, 1 zero-wait first clock, 2 zero-wait with not-ready, 3 plain, 4 two waits
  task automatic pick(input int mode, input int k, output bit r, output bit z);
    case (mode)
      1: begin r = 1; z = (k == 0); end
      2: begin r = (k != 0); z = (k <= 1); end
      3: begin r = 1; z = 0; end
      4: begin r = (k >= 2); z = 0; end
      default: begin r = ($urandom % 4) != 0; z = ($urandom % 5) == 0; end
    endcase
  endtask

  task automatic run_cycle(input logic [26:0] a, input bit wr, input logic [1:0] kind,
                           input int mode, input int exp_len);
    bit rd, low, r, z, m, fin;
    int cnt, k;
    rd  = uses_read(wr, kind);
    low = is_low(a);
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready idle", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_kind = kind;
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0; k = 0; fin = 0; m = 0;
    while (!fin && k < 60) begin
      chk(memr_n == !rd && memw_n == rd, "R3 strobe dir", {memr_n, memw_n}, {!rd, rd});
      chk(smemr_n == !(rd && low && k >= 1), "R4 R5 smemr", smemr_n, !(rd && low && k >= 1));
      chk(smemw_n == !(!rd && low && k >= 1), "R4 R5 smemw", smemw_n, !(!rd && low && k >= 1));
      chk(done == 1'b0, "R9 done early", done, 0);
      pick(mode, k, r, z);
      m = ($urandom % 2) == 1;
      ready = r; zws_n = !z; mem16_n = !m;
      fin = r && (z || cnt == 2);
      if (r) cnt++;
      k++;
      @(negedge clk);
    end
    if (exp_len > 0) chk(k == exp_len, "R6 R7 R8 length", k, exp_len);
    chk(memr_n && memw_n && smemr_n && smemw_n, "R5 release", {memr_n, memw_n, smemr_n, smemw_n}, 4'hf);
    chk(done == 1'b1, "R9 done pulse", done, 1);
    chk(bus16 == m, "R9 bus16", bus16, m);
    ready = 1'b1; zws_n = 1'b1; mem16_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R9 done one clock", done, 0);
  endtask

  initial begin
    #40000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!memrw_oe && smemr_n && smemw_n && !done && !mem16_oe, "R1 reset state",
        {memrw_oe, smemr_n, smemw_n, done, mem16_oe}, 5'b01100);
    rst_n = 1'b1;
    chk(!memrw_oe, "R2 oe before edge", memrw_oe, 0);
    @(negedge clk);
    chk(memrw_oe == 1'b1, "R2 oe after reset", memrw_oe, 1);

    run_cycle(27'h000_1234, 0, 2'd0, 3, 3);   // R6 plain read
    run_cycle(27'h000_4000, 1, 2'd1, 1, 1);   // R7 one clock write
    run_cycle(27'h00F_FFFF, 0, 2'd0, 2, 2);   // R8 zero-wait ignored
    run_cycle(27'h010_0000, 1, 2'd0, 4, 5);   // R4 boundary, R8 waits
    run_cycle(27'h000_0100, 1, 2'd2, 3, 3);   // R3 refresh reads
    run_cycle(27'h7FF_FFFF, 0, 2'd1, 3, 3);   // R4 high address
    for (int i = 0; i < 60; i++) begin
      logic [26:0] a;
      a = ($urandom % 2) ? 27'($urandom % 32'h0010_0000) : 27'($urandom);
      run_cycle(a, $urandom % 2, 2'($urandom % 3), 0, 0);
    end

    // foreign master owns the bus
    @(negedge clk);
    ext_master = 1'b1; ext_addr = 27'h000_8000; ext_main = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!memrw_oe && !req_ready, "R2 ext owns", {memrw_oe, req_ready}, 0);
    chk(!mem16_oe && mem16_n_o, "R11 idle select", mem16_oe, 0);
    ext_memr_n = 1'b0;
    #0;
    chk(mem16_oe && !mem16_n_o, "R11 main mem select", {mem16_oe, mem16_n_o}, 2'b10);
    chk(smemr_n == 1'b1, "R10 delay", smemr_n, 1);
    @(negedge clk);
    chk(smemr_n == 1'b0 && smemw_n, "R10 std read", {smemr_n, smemw_n}, 2'b01);
    ext_memr_n = 1'b1;
    #0;
    chk(smemr_n == 1'b1, "R10 release", smemr_n, 1);
    @(negedge clk);
    ext_main = 1'b0; ext_addr = 27'h020_0000; ext_memw_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(smemw_n == 1'b1 && !mem16_oe, "R10 R11 high ext", {smemw_n, mem16_oe}, 2'b10);
    ext_memw_n = 1'b1; ext_addr = 27'h000_0010;
    @(negedge clk);
    ext_memw_n = 1'b0;
    @(negedge clk);
    chk(smemw_n == 1'b0, "R10 std write", smemw_n, 0);
    ext_memw_n = 1'b1; ext_master = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(memrw_oe == 1'b1, "R2 oe return", memrw_oe, 1);
    run_cycle(27'h000_0040, 0, 2'd0, 3, 3);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule